// File: doc/BRIEF.md
# Double-Width Instruction Fetch Unit

This unit feeds a processor core from a code store whose read port returns two consecutive words per clock. It is built for instruction sets where most instructions take one word and some take two. Each clock it reads the word pair starting at the instruction pointer and sorts the first word into one of three kinds: long, short followed by a padding no-op, or short followed by a real instruction. It then loads the instruction register and moves the pointer on by one or two words. A padding no-op that follows a short instruction is stepped over together with it, so it never costs a clock.

A branch redirect from the core loads the pointer with a target on a pair boundary. The word pair already being fetched is thrown away, which leaves one empty slot on the output. The output side is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the instruction register, its flags, its address and the code-store address all hold still. A word is taken on a cycle where `out_valid` and `out_ready` are both high. A redirect beats back-pressure: a held instruction is dropped when a redirect arrives.

Top module: `dwfetch_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `code_addr` equals `RESET_ADDR` (default 0).
- R2: `code_addr` always shows the instruction pointer. The code store answers with word `code_addr` in `code_rdata[WORD_W-1:0]` and word `code_addr+1` (wrapping) in the upper half.
- R3: A first word whose opcode field (the top `OP_W` bits) has its lowest bit set is long. It is issued with `out_long`=1 and `out_operand` equal to the second word, and the pointer moves on by 2.
- R4: A short first word (opcode lowest bit 0) whose second word is all zeros (the no-op encoding) is issued with `out_operand`=0, and the pointer moves on by 2, stepping over the padding.
- R5: A short first word whose second word is not all zeros is issued with `out_operand`=0, and the pointer moves on by 1.
- R6: With `out_ready` held high and no redirect, one instruction is issued every clock: after a transfer, `out_valid` stays 1.
- R7: While `out_valid`=1, `out_ready`=0 and there is no redirect, every output holds its value on the next clock, and so does `code_addr`.
- R8: A redirect sampled at a clock edge makes `out_valid` 0 for the next cycle. At that point `code_addr` equals the target with bit 0 forced to 0.
- R9: `out_pc` is the word address that the issued instruction's first word came from.
- R10: `out_instr` is the first word of the issued instruction, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_addr | output | ADDR_W | Word address of the pair being read |
| code_rdata | input | 2*WORD_W | Word pair: low half at code_addr, high half at code_addr+1 |
| redirect_valid | input | 1 | Branch redirect request |
| redirect_target | input | ADDR_W | Branch target word address; bit 0 ignored |
| out_valid | output | 1 | Instruction register holds an instruction |
| out_ready | input | 1 | Core accepts the instruction |
| out_instr | output | WORD_W | First word of the issued instruction |
| out_operand | output | WORD_W | Second word for a long instruction, else zero |
| out_long | output | 1 | Issued instruction is two words long |
| out_pc | output | ADDR_W | Word address of the issued instruction |

## Verification
The bench builds the unit with `WORD_W`=16, `OP_W`=4 and `ADDR_W`=6, so the code store has only 64 words. Sequential fetch then runs past the top of the store many times, and the wrap case gets exercised: the pair read at address 63 takes its second word from address 0. The small address space also makes random redirect targets, including odd ones, land often on long instructions, padding and short/short pairs. Because the words are 16 bits wide, the long marker sits at bit 12, which keeps it apart from the low bits of the operand.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  typedef enum logic [1:0] {
    KIND_SHORT        = 2'd0,
    KIND_SHORT_PADDED = 2'd1,
    KIND_LONG         = 2'd2
  } ins_kind_e;

  localparam int LANES = 2;

endpackage

// File: rtl/dwf_classify.sv
module dwf_classify
  import dwf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4
) (
  input  logic [2*WORD_W-1:0] pair,
  output logic [WORD_W-1:0]   first_word,
  output logic [WORD_W-1:0]   operand,
  output logic                is_long,
  output ins_kind_e           kind
);

  localparam int LONG_BIT = WORD_W - OP_W;

  logic [WORD_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = pair[g*WORD_W +: WORD_W];
  end

  logic second_is_pad;

  always_comb begin
    first_word    = lane[0];
    is_long       = lane[0][LONG_BIT];
    second_is_pad = (lane[1] == '0);
    if (is_long) begin
      kind    = KIND_LONG;
      operand = lane[1];
    end else if (second_is_pad) begin
      kind    = KIND_SHORT_PADDED;
      operand = '0;
    end else begin
      kind    = KIND_SHORT;
      operand = '0;
    end
  end

endmodule

// File: rtl/dwf_iptr.sv
module dwf_iptr
  import dwf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  ins_kind_e         kind,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] iptr
);

  localparam logic [ADDR_W-1:0] START = ADDR_W'(RESET_ADDR);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] aligned_target;

  always_comb begin
    step = (kind == KIND_SHORT) ? ADDR_W'(1) : ADDR_W'(2);
    aligned_target = {target[ADDR_W-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iptr <= START;
    end else if (redirect) begin
      iptr <= aligned_target;
    end else if (advance) begin
      iptr <= iptr + step;
    end
  end

endmodule

// File: rtl/dwf_ireg.sv
module dwf_ireg #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              flush,
  input  logic [WORD_W-1:0] in_instr,
  input  logic [WORD_W-1:0] in_operand,
  input  logic              in_long,
  input  logic [ADDR_W-1:0] in_pc,
  output logic              valid,
  output logic [WORD_W-1:0] instr,
  output logic [WORD_W-1:0] operand,
  output logic              is_long,
  output logic [ADDR_W-1:0] pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr   <= '0;
      operand <= '0;
      is_long <= 1'b0;
      pc      <= '0;
    end else if (load && !flush) begin
      instr   <= in_instr;
      operand <= in_operand;
      is_long <= in_long;
      pc      <= in_pc;
    end
  end

endmodule

// File: rtl/dwfetch_unit.sv
module dwfetch_unit
  import dwf_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int OP_W       = 4,
  parameter int ADDR_W     = 10,
  parameter int RESET_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   code_addr,
  input  logic [2*WORD_W-1:0] code_rdata,
  input  logic                redirect_valid,
  input  logic [ADDR_W-1:0]   redirect_target,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_instr,
  output logic [WORD_W-1:0]   out_operand,
  output logic                out_long,
  output logic [ADDR_W-1:0]   out_pc
);

  logic [WORD_W-1:0] f_word;
  logic [WORD_W-1:0] f_operand;
  logic              f_long;
  ins_kind_e         f_kind;
  logic [ADDR_W-1:0] iptr;
  logic              slot_free;
  logic              take;

  assign slot_free = !out_valid || out_ready;
  assign take      = slot_free && !redirect_valid;
  assign code_addr = iptr;

  dwf_classify #(
    .WORD_W (WORD_W),
    .OP_W   (OP_W)
  ) u_classify (
    .pair       (code_rdata),
    .first_word (f_word),
    .operand    (f_operand),
    .is_long    (f_long),
    .kind       (f_kind)
  );

  dwf_iptr #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_iptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (take),
    .kind     (f_kind),
    .redirect (redirect_valid),
    .target   (redirect_target),
    .iptr     (iptr)
  );

  dwf_ireg #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_ireg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .flush      (redirect_valid),
    .in_instr   (f_word),
    .in_operand (f_operand),
    .in_long    (f_long),
    .in_pc      (iptr),
    .valid      (out_valid),
    .instr      (out_instr),
    .operand    (out_operand),
    .is_long    (out_long),
    .pc         (out_pc)
  );

endmodule

// File: rtl/dwfetch_unit_chk.sv
module dwfetch_unit_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] code_addr,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_target,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_instr,
  input logic [WORD_W-1:0] out_operand,
  input logic              out_long,
  input logic [ADDR_W-1:0] out_pc
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

  AST_REDIRECT_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !out_valid); // R8

  AST_REDIRECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (code_addr == {$past(redirect_target[ADDR_W-1:1]), 1'b0})); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect_valid) |=>
      (out_valid && $stable(out_instr) && $stable(out_operand) && $stable(out_pc)
       && $stable(code_addr))); // R7

  AST_STREAM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !redirect_valid) |=> out_valid); // R6

  AST_SHORT_NO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_long) |-> (out_operand == '0)); // R4

  AST_LONG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !redirect_valid && out_long) |=>
      (out_pc == $past(out_pc) + ADDR_W'(2))); // R3

endmodule

bind dwfetch_unit dwfetch_unit_chk #(
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .code_addr       (code_addr),
  .redirect_valid  (redirect_valid),
  .redirect_target (redirect_target),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_instr       (out_instr),
  .out_operand     (out_operand),
  .out_long        (out_long),
  .out_pc          (out_pc)
);

// File: tb/sim_dwfetch_unit.sv
`timescale 1ns/1ps
module sim_dwfetch_unit;

  localparam int WW    = 16;
  localparam int AW    = 6;
  localparam int DEPTH = 64;
  localparam int LBIT  = 12;
  localparam int NCYC  = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] code_addr;
  logic [2*WW-1:0] code_rdata;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_target = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [WW-1:0] out_instr;
  logic [WW-1:0] out_operand;
  logic          out_long;
  logic [AW-1:0] out_pc;

  logic [WW-1:0] mem [DEPTH];

  int n_chk  = 0;
  int n_fail = 0;
  int rs     = 32'h1234_5677;

  always #2 clk = ~clk;

  assign code_rdata = {mem[code_addr + AW'(1)], mem[code_addr]};

  dwfetch_unit #(.WORD_W(WW), .OP_W(4), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .code_addr(code_addr), .code_rdata(code_rdata),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_operand(out_operand), .out_long(out_long), .out_pc(out_pc));

  function automatic int rnd();
    rs = rs * 1103515245 + 12345;
    return (rs >>> 8) & 32'h00FF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int m_ptr, m_valid, m_pc, m_long;
  logic [WW-1:0] m_instr, m_opnd;
  bit rdy_q, redir_q;
  int tgt_q;
  bit stall_q;
  logic [WW-1:0] prev_instr, prev_opnd;
  logic [AW-1:0] prev_pc, prev_addr;

  task automatic model_step();
    logic [WW-1:0] w0, w1;
    if (redir_q) begin
      m_ptr   = tgt_q & ~1;
      m_valid = 0;
    end else if (m_valid == 0 || rdy_q) begin
      w0 = mem[m_ptr];
      w1 = mem[(m_ptr + 1) % DEPTH];
      m_valid = 1;
      m_pc    = m_ptr;
      m_instr = w0;
      m_long  = w0[LBIT];
      m_opnd  = m_long ? w1 : '0;
      if (m_long) m_ptr = (m_ptr + 2) % DEPTH;
      else if (w1 == 0) m_ptr = (m_ptr + 2) % DEPTH;
      else m_ptr = (m_ptr + 1) % DEPTH;
    end
  endtask

  task automatic compare_all();
    chk("R2 code_addr", code_addr, m_ptr);
    chk("R6/R8 out_valid", out_valid, m_valid);
    if (m_valid != 0) begin
      chk("R10 out_instr", out_instr, m_instr);
      chk("R9 out_pc", out_pc, m_pc);
      chk("R3 out_long", out_long, m_long);
      chk("R3/R4/R5 out_operand", out_operand, m_opnd);
    end
    if (stall_q) begin
      chk("R7 held instr", out_instr, prev_instr);
      chk("R7 held operand", out_operand, prev_opnd);
      chk("R7 held pc", out_pc, prev_pc);
      chk("R7 held code_addr", code_addr, prev_addr);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // directed opening program
    mem[0] = 16'h3005;  // long
    mem[1] = 16'hABCD;  // its operand
    mem[2] = 16'h2011;  // short
    mem[3] = 16'h0000;  // padding
    mem[4] = 16'h4022;  // short, next real
    mem[5] = 16'h6033;  // short
    mem[6] = 16'h5044;  // long
    mem[7] = 16'h0F0F;
    for (int i = 8; i < DEPTH; i++) begin
      int r;
      r = rnd();
      mem[i] = ((r & 3) == 0) ? '0 : WW'(r >> 2);
    end

    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset code_addr", code_addr, 0);

    rst_n = 1'b1;
    out_ready = 1'b1;
    redirect_valid = 1'b0;
    m_ptr = 0; m_valid = 0; m_pc = 0; m_long = 0; m_instr = '0; m_opnd = '0;
    rdy_q = 1'b1; redir_q = 1'b0; tgt_q = 0; stall_q = 1'b0;
    chk("R1 first cycle out_valid", out_valid, 0);

    // directed: four issues with ready high
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      model_step();
      compare_all();
      case (k)
        0: begin chk("R3 long pc", out_pc, 0); chk("R3 long operand", out_operand, 16'hABCD); end
        1: chk("R3 long steps by 2", out_pc, 2);
        2: chk("R4 padding skipped", out_pc, 4);
        3: chk("R5 short steps by 1", out_pc, 5);
        default: ;
      endcase
    end

    for (int c = 0; c < NCYC; c++) begin
      int r;
      // remember outputs for the stall check
      prev_instr = out_instr; prev_opnd = out_opnd_w();
      prev_pc = out_pc; prev_addr = code_addr;
      r = rnd();
      out_ready       = ((r & 7) != 0);
      redirect_valid  = (((r >> 3) & 15) == 0);
      redirect_target = AW'(r >> 8);
      stall_q = (m_valid != 0) && !out_ready && !redirect_valid;
      rdy_q = out_ready; redir_q = redirect_valid; tgt_q = int'(redirect_target);
      @(negedge clk);
      model_step();
      compare_all();
      if (redir_q) chk("R8 bubble after redirect", out_valid, 0);
    end
    finish_run();
  end

  function automatic logic [WW-1:0] out_opnd_w();
    return out_operand;
  endfunction

endmodule